// File: doc/BRIEF.md
# Full-duplex I2S master for a stereo audio codec

This block drives a stereo audio codec that runs as a clock slave on its serial audio port. It runs from the codec master clock, forwards that clock to the codec, and divides it into a bit clock and a frame (channel) clock. The playback and record paths share the frame clock. Every frame it takes one left/right pair of playback samples from user logic over a valid/ready handshake. It shifts the pair out MSB first, with the standard one-bit delay after each frame-clock edge. At the same time it gathers the record stream into a left/right pair and presents it with a single-cycle strobe.

With the defaults, a 12.288 MHz master clock divided by four gives a 3.072 MHz bit clock. A frame is 64 bit clocks, so the sample rate is 48 kHz. Each channel half holds 32 bit slots, and a 24-bit sample sits in slots 1 to 24 of the half. The analog outputs stay muted until user logic raises the unmute request. The block then drives the active-low mute pin high.

Top module: `i2s_codec_master`

## Requirements
- R1: While reset is asserted, the bit clock, both channel clocks, the serial data output, the mute pin, `pb_ready` and `rec_valid` are all low. After reset the first frame begins with the left channel.
- R2: The bit clock is the system clock divided by 4. It is high for 2 cycles and low for 2 cycles.
- R3: The channel clock is low (left) for 32 bit-clock periods and then high (right) for 32. The playback and record channel clocks are always equal.
- R4: The channel clock and the serial data output change only in the cycle in which the bit clock falls.
- R5: Slot k of a channel half is counted from 0 at the first rising bit-clock edge after the channel clock changes. Slots 1 to 24 carry sample bits 23 down to 0. Slot 0 and slots 25 to 31 carry 0.
- R6: `pb_ready` is high for exactly one cycle per frame, in the cycle just before the channel clock falls. A pair presented with `pb_valid` high in that cycle is sent in the frame that starts there.
- R7: If `pb_valid` is low when `pb_ready` is high, the frame that follows carries all-zero samples.
- R8: Record data is sampled on the rising bit-clock edge, and only from slots 1 to 24 of each half. After slot 24 of the right half is captured, `rec_valid` pulses for one cycle with the pair on `rec_left` and `rec_right`.
- R9: The mute pin follows `unmute` with one cycle of delay.
- R10: `codec_mclk` carries the system clock unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, equal to the codec master clock |
| rst | input | 1 | Synchronous reset, active high |
| unmute | input | 1 | Request to enable the codec analog outputs |
| pb_left | input | 24 | Playback left sample |
| pb_right | input | 24 | Playback right sample |
| pb_valid | input | 1 | Playback pair is valid |
| pb_ready | output | 1 | Pair is taken in this cycle (frame boundary) |
| rec_left | output | 24 | Received left sample |
| rec_right | output | 24 | Received right sample |
| rec_valid | output | 1 | One-cycle strobe for a new received pair |
| codec_mclk | output | 1 | Master clock toward the codec |
| codec_bclk | output | 1 | Serial bit clock |
| codec_pb_lrc | output | 1 | Playback channel clock (low = left) |
| codec_rec_lrc | output | 1 | Record channel clock (low = left) |
| codec_sdout | output | 1 | Serial playback data |
| codec_sdin | input | 1 | Serial record data |
| codec_mute_n | output | 1 | Active-low mute |

## Verification
Taking a new playback pair and shifting out the last padding bit of the previous right channel fall in the same cycle. This is the bit-clock falling edge that closes the frame. The bench provokes it by streaming frames back to back with sharply different patterns, such as all ones followed by a lone MSB and LSB. It judges every bit of each frame, including slot 0, against the words that were handed over. A second collision pairs that falling edge with the frame-clock change. It is judged by checking that the channel clock and the data move only where the bit clock falls. The record path is fed both a loopback and an inverted loopback. With the inverted feed the padding slots read as ones, so any stray capture outside slots 1 to 24 would corrupt the received pair.

// File: rtl/i2s_cm_pkg.sv
package i2s_cm_pkg;
    // Default geometry: master clock / 4 = bit clock, 32 slots per channel half,
    // 24-bit samples.
    localparam int unsigned DEF_MCLK_PER_BCLK = 4;
    localparam int unsigned DEF_SLOTS_PER_CH  = 32;
    localparam int unsigned DEF_SAMPLE_W      = 24;
endpackage

// File: rtl/i2s_cm_clkgen.sv
module i2s_cm_clkgen #(
    parameter int unsigned MCLK_PER_BCLK = i2s_cm_pkg::DEF_MCLK_PER_BCLK,
    parameter int unsigned SLOTS_PER_CH  = i2s_cm_pkg::DEF_SLOTS_PER_CH,
    localparam int unsigned FRAME_SLOTS  = 2 * SLOTS_PER_CH,
    localparam int unsigned SLOT_W       = $clog2(FRAME_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    output logic              bclk,
    output logic              lrclk,
    output logic [SLOT_W-1:0] slot,
    output logic [SLOT_W-1:0] slot_nxt,
    output logic              rise_stb,
    output logic              fall_stb,
    output logic              frame_end
);
    localparam int unsigned HALF  = MCLK_PER_BCLK / 2;
    localparam int unsigned CNT_W = $clog2(MCLK_PER_BCLK);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [SLOT_W-1:0] slot;
        logic              bclk;
        logic              lrclk;
    } clk_st_t;

    clk_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        rise_stb  = (st_q.cnt == CNT_W'(HALF - 1));
        fall_stb  = (st_q.cnt == CNT_W'(MCLK_PER_BCLK - 1));
        slot_nxt  = (st_q.slot == SLOT_W'(FRAME_SLOTS - 1)) ? '0 : st_q.slot + 1'b1;
        frame_end = fall_stb && (st_q.slot == SLOT_W'(FRAME_SLOTS - 1));
        st_d.cnt  = fall_stb ? '0 : st_q.cnt + 1'b1;
        if (rise_stb) begin
            st_d.bclk = 1'b1;
        end
        if (fall_stb) begin
            st_d.bclk  = 1'b0;
            st_d.slot  = slot_nxt;
            st_d.lrclk = (slot_nxt >= SLOT_W'(SLOTS_PER_CH));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bclk  = st_q.bclk;
    assign lrclk = st_q.lrclk;
    assign slot  = st_q.slot;

    // R3: each frame opens on the left half at slot 0
    assert_frame_opens_left_R3: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (!lrclk && slot == '0));

    // R3: the right half starts exactly at the middle slot
    assert_right_half_start_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(lrclk) |-> (slot == SLOT_W'(SLOTS_PER_CH)));
endmodule

// File: rtl/i2s_cm_tx.sv
module i2s_cm_tx #(
    parameter int unsigned SAMPLE_W     = i2s_cm_pkg::DEF_SAMPLE_W,
    parameter int unsigned SLOTS_PER_CH = i2s_cm_pkg::DEF_SLOTS_PER_CH,
    parameter int unsigned SLOT_W       = $clog2(2 * SLOTS_PER_CH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fall_stb,
    input  logic                frame_end,
    input  logic [SLOT_W-1:0]   slot_nxt,
    input  logic [SAMPLE_W-1:0] pb_left,
    input  logic [SAMPLE_W-1:0] pb_right,
    input  logic                pb_valid,
    output logic                pb_ready,
    output logic                sdout
);
    localparam int unsigned IDX_W = $clog2(SAMPLE_W + 1);

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
        logic                sd;
    } tx_st_t;

    tx_st_t st_d, st_q;

    logic                is_right;
    logic [SLOT_W-1:0]   pos;
    logic [SAMPLE_W-1:0] word;
    logic [IDX_W-1:0]    idx;
    logic                next_bit;

    always_comb begin
        st_d     = st_q;
        pb_ready = frame_end;
        is_right = (slot_nxt >= SLOT_W'(SLOTS_PER_CH));
        pos      = is_right ? slot_nxt - SLOT_W'(SLOTS_PER_CH) : slot_nxt;
        word     = is_right ? st_q.right : st_q.left;
        idx      = IDX_W'(SAMPLE_W) - IDX_W'(pos);
        next_bit = 1'b0;
        if (pos >= SLOT_W'(1) && pos <= SLOT_W'(SAMPLE_W)) begin
            next_bit = word[idx];
        end
        if (frame_end) begin
            st_d.left  = pb_valid ? pb_left  : '0;
            st_d.right = pb_valid ? pb_right : '0;
        end
        if (fall_stb) begin
            st_d.sd = next_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdout = st_q.sd;

    // R6: the handshake window is a single cycle
    assert_ready_single_R6: assert property (@(posedge clk) disable iff (rst)
        pb_ready |=> !pb_ready);
endmodule

// File: rtl/i2s_cm_rx.sv
module i2s_cm_rx #(
    parameter int unsigned SAMPLE_W     = i2s_cm_pkg::DEF_SAMPLE_W,
    parameter int unsigned SLOTS_PER_CH = i2s_cm_pkg::DEF_SLOTS_PER_CH,
    parameter int unsigned SLOT_W       = $clog2(2 * SLOTS_PER_CH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rise_stb,
    input  logic [SLOT_W-1:0]   slot,
    input  logic                sdin,
    output logic [SAMPLE_W-1:0] rec_left,
    output logic [SAMPLE_W-1:0] rec_right,
    output logic                rec_valid
);
    typedef struct packed {
        logic [SAMPLE_W-1:0] sh_l;
        logic [SAMPLE_W-1:0] sh_r;
        logic [SAMPLE_W-1:0] out_l;
        logic [SAMPLE_W-1:0] out_r;
        logic                vld;
    } rx_st_t;

    rx_st_t st_d, st_q;

    logic              is_right;
    logic [SLOT_W-1:0] pos;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        is_right = (slot >= SLOT_W'(SLOTS_PER_CH));
        pos      = is_right ? slot - SLOT_W'(SLOTS_PER_CH) : slot;
        if (rise_stb && pos >= SLOT_W'(1) && pos <= SLOT_W'(SAMPLE_W)) begin
            if (is_right) begin
                st_d.sh_r = {st_q.sh_r[SAMPLE_W-2:0], sdin};
                if (pos == SLOT_W'(SAMPLE_W)) begin
                    st_d.out_l = st_q.sh_l;
                    st_d.out_r = {st_q.sh_r[SAMPLE_W-2:0], sdin};
                    st_d.vld   = 1'b1;
                end
            end else begin
                st_d.sh_l = {st_q.sh_l[SAMPLE_W-2:0], sdin};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rec_left  = st_q.out_l;
    assign rec_right = st_q.out_r;
    assign rec_valid = st_q.vld;

    // R8: a received pair is flagged for one cycle only
    assert_valid_single_R8: assert property (@(posedge clk) disable iff (rst)
        rec_valid |=> !rec_valid);
endmodule

// File: rtl/i2s_codec_master.sv
module i2s_codec_master #(
    parameter int unsigned MCLK_PER_BCLK = i2s_cm_pkg::DEF_MCLK_PER_BCLK,
    parameter int unsigned SLOTS_PER_CH  = i2s_cm_pkg::DEF_SLOTS_PER_CH,
    parameter int unsigned SAMPLE_W      = i2s_cm_pkg::DEF_SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                unmute,
    input  logic [SAMPLE_W-1:0] pb_left,
    input  logic [SAMPLE_W-1:0] pb_right,
    input  logic                pb_valid,
    output logic                pb_ready,
    output logic [SAMPLE_W-1:0] rec_left,
    output logic [SAMPLE_W-1:0] rec_right,
    output logic                rec_valid,
    output logic                codec_mclk,
    output logic                codec_bclk,
    output logic                codec_pb_lrc,
    output logic                codec_rec_lrc,
    output logic                codec_sdout,
    input  logic                codec_sdin,
    output logic                codec_mute_n
);
    localparam int unsigned SLOT_W = $clog2(2 * SLOTS_PER_CH);

    typedef struct packed {
        logic mute_n;
    } top_st_t;

    top_st_t st_d, st_q;

    logic              bclk, lrclk, rise_stb, fall_stb, frame_end;
    logic [SLOT_W-1:0] slot, slot_nxt;

    i2s_cm_clkgen #(
        .MCLK_PER_BCLK (MCLK_PER_BCLK),
        .SLOTS_PER_CH  (SLOTS_PER_CH)
    ) i_clkgen (
        .clk       (clk),
        .rst       (rst),
        .bclk      (bclk),
        .lrclk     (lrclk),
        .slot      (slot),
        .slot_nxt  (slot_nxt),
        .rise_stb  (rise_stb),
        .fall_stb  (fall_stb),
        .frame_end (frame_end)
    );

    i2s_cm_tx #(
        .SAMPLE_W     (SAMPLE_W),
        .SLOTS_PER_CH (SLOTS_PER_CH),
        .SLOT_W       (SLOT_W)
    ) i_tx (
        .clk       (clk),
        .rst       (rst),
        .fall_stb  (fall_stb),
        .frame_end (frame_end),
        .slot_nxt  (slot_nxt),
        .pb_left   (pb_left),
        .pb_right  (pb_right),
        .pb_valid  (pb_valid),
        .pb_ready  (pb_ready),
        .sdout     (codec_sdout)
    );

    i2s_cm_rx #(
        .SAMPLE_W     (SAMPLE_W),
        .SLOTS_PER_CH (SLOTS_PER_CH),
        .SLOT_W       (SLOT_W)
    ) i_rx (
        .clk       (clk),
        .rst       (rst),
        .rise_stb  (rise_stb),
        .slot      (slot),
        .sdin      (codec_sdin),
        .rec_left  (rec_left),
        .rec_right (rec_right),
        .rec_valid (rec_valid)
    );

    always_comb begin
        st_d        = st_q;
        st_d.mute_n = unmute;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign codec_mclk    = clk;
    assign codec_bclk    = bclk;
    assign codec_pb_lrc  = lrclk;
    assign codec_rec_lrc = lrclk;
    assign codec_mute_n  = st_q.mute_n;

    // R4: the channel clock moves only with a falling bit clock
    assert_lrc_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(lrclk) |-> $fell(bclk));

    // R4: the playback data moves only with a falling bit clock
    assert_sdout_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(codec_sdout) |-> $fell(bclk));

    // R6: taking a pair is followed at once by the start of the left half
    assert_ready_then_left_R6: assert property (@(posedge clk) disable iff (rst)
        pb_ready |=> $fell(lrclk));

    // R8: a received pair is flagged while the right half is on the wire
    assert_valid_in_right_R8: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> lrclk);
endmodule

// File: tb/test_i2s_codec_master.sv
module test_i2s_codec_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        unmute = 1'b0;
    logic [23:0] pb_left = '0, pb_right = '0;
    logic        pb_valid = 1'b0;
    logic        pb_ready;
    logic [23:0] rec_left, rec_right;
    logic        rec_valid;
    logic        mclk, bclk, pb_lrc, rec_lrc, sdout, sdin, mute_n;
    logic [1:0]  sd_src = 2'd0;   // 0: zero, 1: loopback, 2: inverted loopback

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    assign sdin = (sd_src == 2'd1) ? sdout : (sd_src == 2'd2) ? ~sdout : 1'b0;

    i2s_codec_master i_i2s_codec_master (
        .clk(clk), .rst(rst), .unmute(unmute),
        .pb_left(pb_left), .pb_right(pb_right), .pb_valid(pb_valid), .pb_ready(pb_ready),
        .rec_left(rec_left), .rec_right(rec_right), .rec_valid(rec_valid),
        .codec_mclk(mclk), .codec_bclk(bclk), .codec_pb_lrc(pb_lrc),
        .codec_rec_lrc(rec_lrc), .codec_sdout(sdout), .codec_sdin(sdin),
        .codec_mute_n(mute_n)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic exp_bit(int k, logic [23:0] l, logic [23:0] r);
        int          p = k % 32;
        logic [23:0] w = (k < 32) ? l : r;
        if (p >= 1 && p <= 24) return w[24 - p];
        return 1'b0;
    endfunction

    // Hands over one pair at the frame boundary and checks the whole frame.
    task automatic play_frame(input logic [23:0] l, input logic [23:0] r,
                              input logic give, input logic [1:0] src, input string dreq,
                              output logic [23:0] got_l, output logic [23:0] got_r,
                              output int nvalid);
        int guard = 0;
        int k = 0;
        int bit_err = 0, lr_err = 0, edge_err = 0;
        logic prev_b, prev_lr;
        logic [23:0] el = give ? l : 24'h0;
        logic [23:0] er = give ? r : 24'h0;
        got_l = 'x; got_r = 'x; nvalid = 0;
        sd_src = src;
        pb_left = l; pb_right = r; pb_valid = give;
        step();
        while (!pb_ready && guard < 400) begin
            step();
            guard++;
        end
        check("R6", "ready seen within a frame", 32'(pb_ready), 32'd1);
        step();
        pb_valid = 1'b0;
        check("R6", "ready width one cycle", 32'(pb_ready), 32'd0);
        check("R6", "left half starts after ready", 32'(pb_lrc), 32'd0);
        prev_b = bclk; prev_lr = pb_lrc;
        while (k < 64) begin
            step();
            if (rec_valid) begin
                nvalid++;
                got_l = rec_left;
                got_r = rec_right;
            end
            if (pb_lrc !== prev_lr && !(prev_b && !bclk)) edge_err++;
            if (bclk && !prev_b) begin
                if (sdout !== exp_bit(k, el, er)) bit_err++;
                if (pb_lrc !== (k >= 32)) lr_err++;
                k++;
            end
            prev_b = bclk; prev_lr = pb_lrc;
        end
        check(dreq, "serial bits wrong in frame", 32'(bit_err), 32'd0);
        check("R3", "channel clock level per slot", 32'(lr_err), 32'd0);
        check("R4", "channel clock moved off a bclk fall", 32'(edge_err), 32'd0);
    endtask

    task automatic t_reset_r1();
        rst = 1'b1;
        repeat (5) step();
        check("R1", "bclk in reset", 32'(bclk), 32'd0);
        check("R1", "channel clocks in reset", {30'd0, pb_lrc, rec_lrc}, 32'd0);
        check("R1", "sdout in reset", 32'(sdout), 32'd0);
        check("R1", "mute_n in reset", 32'(mute_n), 32'd0);
        check("R1", "ready/valid in reset", {30'd0, pb_ready, rec_valid}, 32'd0);
        check("R10", "mclk low phase", 32'(mclk), 32'd0);
        @(posedge clk); #1;
        check("R10", "mclk high phase", 32'(mclk), 32'd1);
        step();
        rst = 1'b0;
    endtask

    task automatic t_clocks_r2_r3();
        int hi = 0, lo = 0, guard = 0, rises = 0, lr_diff = 0;
        logic prev_b, prev_lr;
        step();
        check("R1", "first half after reset is left", 32'(pb_lrc), 32'd0);
        prev_b = bclk;
        while (!(bclk && !prev_b) && guard < 20) begin prev_b = bclk; step(); guard++; end
        while (bclk)  begin hi++; step(); end
        while (!bclk) begin lo++; step(); end
        check("R2", "bclk high cycles", 32'(hi), 32'd2);
        check("R2", "bclk low cycles", 32'(lo), 32'd2);
        // align to a channel clock fall
        prev_lr = pb_lrc; guard = 0;
        while (!(prev_lr && !pb_lrc) && guard < 600) begin prev_lr = pb_lrc; step(); guard++; end
        prev_b = bclk;
        while (!pb_lrc) begin
            if (pb_lrc !== rec_lrc) lr_diff++;
            if (bclk && !prev_b) rises++;
            prev_b = bclk; step();
        end
        check("R3", "bclk periods in left half", 32'(rises), 32'd32);
        rises = 0;
        while (pb_lrc) begin
            if (pb_lrc !== rec_lrc) lr_diff++;
            if (bclk && !prev_b) rises++;
            prev_b = bclk; step();
        end
        check("R3", "bclk periods in right half", 32'(rises), 32'd32);
        check("R3", "playback vs record channel clock", 32'(lr_diff), 32'd0);
    endtask

    task automatic t_loopback_r5_r8();
        logic [23:0] gl, gr; int nv;
        play_frame(24'hA5C3F1, 24'h1234EF, 1'b1, 2'd1, "R5", gl, gr, nv);
        check("R8", "valid pulses per frame", 32'(nv), 32'd1);
        check("R8", "received left", 32'(gl), 32'h00A5C3F1);
        check("R8", "received right", 32'(gr), 32'h001234EF);
    endtask

    task automatic t_back_to_back_r5();
        logic [23:0] gl, gr; int nv;
        play_frame(24'hFFFFFF, 24'h800001, 1'b1, 2'd1, "R5", gl, gr, nv);
        check("R5", "boundary words loop back left", 32'(gl), 32'h00FFFFFF);
        check("R5", "boundary words loop back right", 32'(gr), 32'h00800001);
        play_frame(24'h000001, 24'h7FFFFE, 1'b1, 2'd1, "R5", gl, gr, nv);
        check("R6", "next frame takes new left", 32'(gl), 32'h00000001);
        check("R6", "next frame takes new right", 32'(gr), 32'h007FFFFE);
    endtask

    task automatic t_pad_ignored_r8();
        logic [23:0] gl, gr; int nv;
        play_frame(24'h3C0F96, 24'hC30F69, 1'b1, 2'd2, "R5", gl, gr, nv);
        check("R8", "inverted feed left, pads ignored", 32'(gl), 32'h00C3F069);
        check("R8", "inverted feed right, pads ignored", 32'(gr), 32'h003CF096);
    endtask

    task automatic t_underrun_r7();
        logic [23:0] gl, gr; int nv;
        play_frame(24'h5A5A5A, 24'hA5A5A5, 1'b0, 2'd1, "R7", gl, gr, nv);
        check("R7", "silent frame received left", 32'(gl), 32'h0);
        check("R7", "silent frame received right", 32'(gr), 32'h0);
    endtask

    task automatic t_mute_r9();
        unmute = 1'b1;
        check("R9", "mute_n before register", 32'(mute_n), 32'd0);
        step();
        check("R9", "mute_n released", 32'(mute_n), 32'd1);
        unmute = 1'b0;
        step();
        check("R9", "mute_n reasserted", 32'(mute_n), 32'd0);
        unmute = 1'b1;
        rst = 1'b1;
        repeat (2) step();
        check("R1", "mute_n held low in reset", 32'(mute_n), 32'd0);
        rst = 1'b0;
        unmute = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        t_reset_r1();
        t_clocks_r2_r3();
        t_loopback_r5_r8();
        t_back_to_back_r5();
        t_pad_ignored_r8();
        t_underrun_r7();
        t_mute_r9();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule